// File: doc/BRIEF.md
# Operand Fetch Counter with Read-Tag Routing

This block resolves instruction operands that need chained memory reads before they can be used. Each operand slot is loaded with a starting value and a two-bit addressing mode. The mode sets how many reads remain. While that count is nonzero, the slot's current value goes to memory as a read address. Each response replaces the value and lowers the count by one. When the count reaches zero, the slot hands its value to the arithmetic unit for one cycle and becomes free again.

All slots share one memory read port. Only one read may be outstanding at a time. A set/reset tag flag per slot records which slot issued that read. The flag is set when the read is issued, and the arrival strobe of the response clears it. Response data reaches only the slot whose flag is set. The remaining-read count of each slot is held in a chain of toggle stages. Each stage flips when the stage below it borrows.

Top module: `operand_fetch_unit`

## Requirements
- R1: After reset no slot is busy, `mem_req` is 0 and `alu_valid` is all zeros.
- R2: A slot captures `ld_value` and `ld_mode` only when it is idle and its `ld_valid` bit is 1. A load pulse to a busy slot, including in the cycle its result is presented, has no effect on that slot's result.
- R3: Mode 0 (`ld_mode` bits 2s+1:2s equal to 0) presents the loaded value on `alu_data` with `alu_valid[s]` high in the cycle after the load edge, with no memory read.
- R4: Mode k (1 to 3) makes the slot issue exactly k reads. Each read address equals the slot's current value, and each response replaces that value, so the result is the k-fold memory lookup of the loaded value.
- R5: At most one read is outstanding. `mem_req` stays 0 from the edge where a read is issued up to and including the edge where its response arrives.
- R6: When several slots want a read in the same cycle, the lowest-numbered slot is granted first.
- R7: A response goes only to the slot whose tag flag is set, and it clears that flag. A response with no read outstanding changes no slot.
- R8: When a busy slot's count is zero, `alu_valid[s]` is high for exactly one cycle with the final value on `alu_data` bits W*s+W-1:W*s. The slot is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | NSLOT | Per-slot load strobe |
| ld_mode | input | 2*NSLOT | Per-slot addressing mode, slot s in bits 2s+1:2s |
| ld_value | input | W*NSLOT | Per-slot starting value, slot s in bits W*s+W-1:W*s |
| mem_req | output | 1 | Read issued this cycle |
| mem_addr | output | W | Read address (value of the granted slot) |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | W | Read response data |
| alu_valid | output | NSLOT | Per-slot result strobe |
| alu_data | output | W*NSLOT | Per-slot result value |

## Verification
The bench pairs two slots with random modes and random response delays. It compares each result with a chained lookup in its own memory model. A wrong toggle-borrow chain would give the wrong number of reads and a wrong result. Misrouted tags would swap or corrupt the two slots' values. Further directed cases target the following: a second read issued while one is pending (a design allowing this would show `mem_req` during the wait), the lower slot losing a tie (the first address seen would be the upper slot's value), a reload while busy that overwrites state, and a stray response with nothing outstanding that corrupts an idle slot.

// File: rtl/ofu_pkg.sv
package ofu_pkg;
  localparam int MODE_W = 2;
  typedef logic [MODE_W-1:0] mode_t;

  // reads left after one more response
  function automatic mode_t reads_left_after(mode_t c);
    return c - mode_t'(1);
  endfunction
endpackage

// File: rtl/ofu_toggle_counter.sv
module ofu_toggle_counter
  import ofu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  mode_t preset,
  input  logic  step,
  output mode_t count,
  output logic  zero
);
  mode_t q;
  mode_t flip;

  // stage 0 flips on every step; stage i flips when stage i-1 borrows (goes 0->1)
  assign flip[0] = step;
  generate
    for (genvar i = 1; i < MODE_W; i++) begin : g_stage
      assign flip[i] = flip[i-1] & ~q[i-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= preset;
    else           q <= q ^ flip;
  end

  assign count = q;
  assign zero  = (q == '0);

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> count == reads_left_after($past(count)));
  a_r4_no_step_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !zero);
endmodule

// File: rtl/ofu_slot.sv
module ofu_slot
  import ofu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_valid,
  input  mode_t        ld_mode,
  input  logic [W-1:0] ld_value,
  input  logic         rsp_hit,
  input  logic [W-1:0] rsp_data,
  output logic         want_read,
  output logic [W-1:0] value,
  output logic         alu_valid
);
  logic  busy;
  logic  accept;
  logic  zero;
  mode_t count;

  assign accept    = ld_valid && !busy;
  assign want_read = busy && !zero;
  assign alu_valid = busy && zero;

  ofu_toggle_counter i_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .preset (ld_mode),
    .step   (rsp_hit),
    .count  (count),
    .zero   (zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      value <= '0;
    end else begin
      if (accept) begin
        busy  <= 1'b1;
        value <= ld_value;
      end else if (rsp_hit) begin
        value <= rsp_data;
      end
      if (alu_valid) busy <= 1'b0;
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid |=> !alu_valid);
  a_r7_hit_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> want_read);
  a_r2_busy_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_hit && !alu_valid) |=> $stable(count));
endmodule

// File: rtl/ofu_tag_store.sv
module ofu_tag_store #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] issue,
  input  logic             rsp_valid,
  output logic [NSLOT-1:0] flags,
  output logic [NSLOT-1:0] hit,
  output logic             pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= issue | (flags & ~{NSLOT{rsp_valid}});
  end

  assign hit     = flags & {NSLOT{rsp_valid}};
  assign pending = |flags;

  a_r5_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags) <= 1);
  a_r7_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pending) |=> flags == '0);
  a_r7_set_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (issue != '0) |=> flags == $past(issue));
endmodule

// File: rtl/operand_fetch_unit.sv
module operand_fetch_unit
  import ofu_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSLOT-1:0]    ld_valid,
  input  logic [2*NSLOT-1:0]  ld_mode,
  input  logic [W*NSLOT-1:0]  ld_value,
  output logic                mem_req,
  output logic [W-1:0]        mem_addr,
  input  logic                rsp_valid,
  input  logic [W-1:0]        rsp_data,
  output logic [NSLOT-1:0]    alu_valid,
  output logic [W*NSLOT-1:0]  alu_data
);
  logic [NSLOT-1:0] want;
  logic [NSLOT-1:0] grant;
  logic [NSLOT-1:0] flags;
  logic [NSLOT-1:0] hit;
  logic             pending;
  logic [W-1:0]     value [NSLOT];

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      ofu_slot #(.W(W)) i_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid[s]),
        .ld_mode   (ld_mode[MODE_W*s +: MODE_W]),
        .ld_value  (ld_value[W*s +: W]),
        .rsp_hit   (hit[s]),
        .rsp_data  (rsp_data),
        .want_read (want[s]),
        .value     (value[s]),
        .alu_valid (alu_valid[s])
      );
      assign alu_data[W*s +: W] = value[s];
    end
  endgenerate

  // fixed priority, lowest index first, only when nothing outstanding
  always_comb begin
    grant    = '0;
    mem_addr = '0;
    if (!pending) begin
      for (int s = NSLOT - 1; s >= 0; s--) begin
        if (want[s]) begin
          grant    = '0;
          grant[s] = 1'b1;
          mem_addr = value[s];
        end
      end
    end
  end
  assign mem_req = |grant;

  ofu_tag_store #(.NSLOT(NSLOT)) i_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (grant),
    .rsp_valid (rsp_valid),
    .flags     (flags),
    .hit       (hit),
    .pending   (pending)
  );

  a_r5_no_issue_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !mem_req);
  a_r6_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    (want[0] && !pending) |-> grant[0]);
  a_r6_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!mem_req && alu_valid == '0));
endmodule

// File: tb/test_operand_fetch_unit.sv
module test_operand_fetch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 2;
  localparam int W = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NSLOT-1:0]    ld_valid = '0;
  logic [2*NSLOT-1:0]  ld_mode = '0;
  logic [W*NSLOT-1:0]  ld_value = '0;
  logic                mem_req;
  logic [W-1:0]        mem_addr;
  logic                rsp_valid = 1'b0;
  logic [W-1:0]        rsp_data = '0;
  logic [NSLOT-1:0]    alu_valid;
  logic [W*NSLOT-1:0]  alu_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_fetch_unit #(.NSLOT(NSLOT), .W(W)) i_operand_fetch_unit (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_mode(ld_mode),
    .ld_value(ld_value), .mem_req(mem_req), .mem_addr(mem_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .alu_valid(alu_valid),
    .alu_data(alu_data));

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mem_word(input logic [W-1:0] a);
    return W'(32'(a) * 32'd40503 + 32'd12345);
  endfunction

  function automatic logic [W-1:0] chase(input logic [W-1:0] v, input int k);
    logic [W-1:0] x = v;
    for (int i = 0; i < k; i++) x = mem_word(x);
    return x;
  endfunction

  // memory model and result monitor, all at the falling edge
  int           pend = 0;
  logic [W-1:0] pend_addr = '0;
  int           reads = 0;
  bit           first_seen = 0;
  logic [W-1:0] first_addr = '0;
  bit           stray_req = 0;
  int           pulses [NSLOT];
  logic [W-1:0] got [NSLOT];
  int           early_r5 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      rsp_valid = 1'b0;
      if (mem_req && pend > 0) early_r5++;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = mem_word(pend_addr);
        end
      end else if (stray_req) begin
        rsp_valid = 1'b1;
        rsp_data  = 16'hDEAD;
        stray_req = 0;
      end else if (mem_req) begin
        pend_addr = mem_addr;
        reads++;
        if (!first_seen) begin first_seen = 1; first_addr = mem_addr; end
        pend = 1 + int'($urandom % 3);
      end
      for (int s = 0; s < NSLOT; s++)
        if (alu_valid[s]) begin
          pulses[s]++;
          got[s] = alu_data[W*s +: W];
        end
    end
  end

  task automatic clear_mon();
    reads = 0; first_seen = 0;
    for (int s = 0; s < NSLOT; s++) begin pulses[s] = 0; got[s] = '0; end
  endtask

  task automatic run_pair(input int m0, input logic [W-1:0] v0, input int m1,
                          input logic [W-1:0] v1, input bit reload);
    int wait_n = 0;
    clear_mon();
    @(negedge clk);
    ld_valid = 2'b11;
    ld_mode  = {2'(m1), 2'(m0)};
    ld_value = {v1, v0};
    @(negedge clk);
    // R2: reload attempt to busy slots carries junk
    ld_valid = reload ? 2'b11 : 2'b00;
    ld_mode  = 4'b0000;
    ld_value = {16'hFFFF, 16'hFFFF};
    @(negedge clk);
    ld_valid = '0;
    while ((pulses[0] == 0 || pulses[1] == 0) && wait_n < 300) begin
      @(negedge clk);
      wait_n++;
    end
    repeat (4) @(negedge clk);
    chk(got[0] == chase(v0, m0), "R4 slot0 result", got[0], chase(v0, m0));
    chk(got[1] == chase(v1, m1), "R4 slot1 result", got[1], chase(v1, m1));
    chk(pulses[0] == 1 && pulses[1] == 1, "R8 one pulse each",
        {pulses[1][15:0], pulses[0][15:0]}, 32'h0001_0001);
    chk(reads == m0 + m1, "R4 read count", reads, m0 + m1);
    if (m0 + m1 > 0) begin
      logic [W-1:0] e = (m0 > 0) ? v0 : v1;
      chk(first_addr == e, "R6 lower slot first", first_addr, e);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_mon();
    repeat (4) @(negedge clk);
    chk(mem_req == 1'b0 && alu_valid == '0, "R1 reset outputs",
        {mem_req, alu_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0 && alu_valid == '0, "R1 idle after reset",
        {mem_req, alu_valid}, 0);

    // R3: mode 0 presents in the cycle after the load edge
    clear_mon();
    ld_valid = 2'b11; ld_mode = 4'b0000; ld_value = {16'h1234, 16'hABCD};
    @(negedge clk);
    ld_valid = '0;
    chk(alu_valid == 2'b11, "R3 mode0 valid next cycle", alu_valid, 2'b11);
    chk(alu_data == {16'h1234, 16'hABCD}, "R3 mode0 data", alu_data,
        {16'h1234, 16'hABCD});
    chk(mem_req == 1'b0, "R3 mode0 no read", mem_req, 0);
    @(negedge clk);
    chk(alu_valid == 2'b00, "R8 pulse ends", alu_valid, 0);

    // R7: stray response with nothing outstanding, then plain pass-through
    stray_req = 1;
    repeat (3) @(negedge clk);
    run_pair(0, 16'h0F0F, 0, 16'h7070, 1'b0);
    chk(got[0] == 16'h0F0F && got[1] == 16'h7070, "R7 stray ignored",
        {got[1], got[0]}, {16'h7070, 16'h0F0F});

    // directed: each depth, tie, and reload while busy
    run_pair(1, 16'h0001, 0, 16'h0002, 1'b1);
    run_pair(0, 16'h0003, 2, 16'h0004, 1'b1);
    run_pair(3, 16'hFFFF, 3, 16'h0000, 1'b1);
    run_pair(2, 16'h1111, 1, 16'h2222, 1'b0);

    for (int i = 0; i < 40; i++)
      run_pair(int'($urandom % 4), 16'($urandom), int'($urandom % 4),
               16'($urandom), 1'($urandom));

    chk(early_r5 == 0, "R5 no request while pending", early_r5, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule